// File: doc/BRIEF.md
# Transmit Completion Tag Tracker

This block keeps track of transmit packets that are in flight, each one known by a 16-bit completion tag. A producer registers a packet on the submit port with its tag and the number of ring descriptors it occupies. The block then takes a stream of typed completion events. A normal packet is finished by a single packet completion. A packet routed through the flow-miss path first gets a miss completion and is finished only by a later reinjection completion. Descriptor completions carry a count of freed ring slots and finish no packet. Completions for different tags may arrive in any order relative to submission.

Each tracked tag has its own small state machine with the states free, pending, missed and done, held in a table indexed by the low tag bits. The table also stores the upper tag bits, so a completion whose tag only aliases an occupied entry is rejected. When a packet finishes, the block emits a one-cycle done pulse carrying the full tag. Freed descriptor counts accumulate in a counter that the consumer clears with an acknowledge. Every illegal event raises a one-cycle error flag and leaves all state as it was.

Top module: `tx_cmpl_tracker`

## Requirements
- R1: After reset, done_o and err_o are low, freed_o is 0, every table entry is free and the outstanding descriptor total is 0.
- R2: A submit whose table entry (tag bits [3:0] by default) is free makes that entry pending. A submit to an entry that is not free sets err_o in the next cycle and changes nothing.
- R3: A packet completion (type 0) on a pending tag with matching upper bits pulses done_o with done_tag_o equal to that tag in the next cycle. The entry then stays done for one cycle and is free from the cycle after that, so a submit in the cycle of the done pulse is an error.
- R4: A miss completion (type 2) on a pending tag makes it missed without a done pulse. A later reinjection completion (type 3) on the missed tag pulses done_o with the tag.
- R5: A packet completion on a missed tag sets err_o, gives no done pulse and leaves the tag missed.
- R6: A reinjection completion on a pending tag sets err_o and leaves the tag pending.
- R7: A packet, miss or reinjection completion on a free entry, or on an entry whose stored upper tag bits differ from the completion's, sets err_o and changes nothing.
- R8: A descriptor completion (type 1) adds its count to freed_o in the next cycle and subtracts it from the outstanding total that submits increase. Its tag is ignored, no entry changes state and no done pulse is produced.
- R9: freed_ack_i clears freed_o in the next cycle. When it coincides with a descriptor completion, freed_o becomes that completion's count.
- R10: A descriptor completion whose count exceeds the outstanding descriptor total sets err_o and leaves freed_o and the total unchanged.
- R11: Completions for different tags are accepted in any order relative to their submission.
- R12: A submit and a completion presented in the same cycle are both processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_valid_i | input | 1 | Submit strobe |
| sub_tag_i | input | 16 | Completion tag of the submitted packet |
| sub_ndesc_i | input | 5 | Descriptors used by the submitted packet |
| cmp_valid_i | input | 1 | Completion strobe |
| cmp_type_i | input | 2 | 0 packet, 1 descriptor, 2 miss, 3 reinjection |
| cmp_tag_i | input | 16 | Tag of the completion (ignored for descriptor type) |
| cmp_ndesc_i | input | 5 | Freed descriptors (descriptor type only) |
| freed_ack_i | input | 1 | Clears the freed-descriptor counter |
| done_o | output | 1 | One-cycle pulse: a packet has finished |
| done_tag_o | output | 16 | Tag of the finished packet |
| freed_o | output | 12 | Accumulated freed descriptors |
| err_o | output | 1 | One-cycle pulse: an illegal event was seen |

## Verification
The hardest condition to reach from the ports is the single cycle in which an entry sits in its done state, because it lasts only one clock after the pulse. The stimulus table places a submit to the same index exactly in the cycle of the done pulse and expects an error, then submits again one cycle later and expects acceptance. Aliasing is reached by completing a tag whose low bits select a pending entry but whose upper bits differ. Out-of-order finishing is reached by completing the second-submitted tag before the first one, and by carrying the first one through a miss and a rejected packet completion before its reinjection.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_PEND = 2'd1,
    ST_MISS = 2'd2,
    ST_DONE = 2'd3
  } slot_st_e;

  typedef enum logic [1:0] {
    CT_PKT   = 2'd0,
    CT_DESC  = 2'd1,
    CT_MISS  = 2'd2,
    CT_REINJ = 2'd3
  } cmpl_e;
endpackage

// File: rtl/tct_slot.sv
module tct_slot
  import tct_pkg::*;
#(
  parameter int HI_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sub_go_i,
  input  logic [HI_W-1:0] sub_hi_i,
  input  logic            adv_i,
  input  slot_st_e        adv_st_i,
  output slot_st_e        st_o,
  output logic [HI_W-1:0] hi_o
);
  slot_st_e        st_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_FREE;
      hi_q <= '0;
    end else if (sub_go_i) begin
      st_q <= ST_PEND;
      hi_q <= sub_hi_i;
    end else if (adv_i) begin
      st_q <= adv_st_i;
    end else if (st_q == ST_DONE) begin
      st_q <= ST_FREE;  // done lasts one cycle
    end
  end

  assign st_o = st_q;
  assign hi_o = hi_q;

  p_done_frees_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DONE |=> st_q == ST_FREE);

  p_miss_from_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MISS && $past(st_q) != ST_MISS) |-> $past(st_q) == ST_PEND);

  p_pend_from_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PEND && $past(st_q) != ST_PEND) |-> $past(st_q) == ST_FREE);
endmodule

// File: rtl/tct_desc_acct.sv
module tct_desc_acct #(
  parameter int CNT_W   = 5,
  parameter int OUT_W   = 9,
  parameter int FREED_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               add_i,
  input  logic [CNT_W-1:0]   add_n_i,
  input  logic               rel_req_i,
  input  logic [CNT_W-1:0]   rel_n_i,
  input  logic               ack_i,
  output logic [FREED_W-1:0] freed_o,
  output logic               rel_bad_o
);
  localparam logic [FREED_W:0] FREED_MAX = {1'b0, {FREED_W{1'b1}}};

  logic [OUT_W-1:0]   out_q, out_d, add_ext, rel_ext;
  logic [FREED_W-1:0] freed_q, freed_base;
  logic [FREED_W:0]   freed_sum;
  logic               rel_ok;

  assign add_ext   = OUT_W'(add_n_i);
  assign rel_ext   = OUT_W'(rel_n_i);
  assign rel_ok    = rel_req_i && (rel_ext <= out_q);
  assign rel_bad_o = rel_req_i && !rel_ok;

  always_comb begin
    out_d = out_q;
    if (add_i)  out_d = out_d + add_ext;
    if (rel_ok) out_d = out_d - rel_ext;
    freed_base = ack_i ? '0 : freed_q;
    freed_sum  = {1'b0, freed_base} + (rel_ok ? (FREED_W+1)'(rel_n_i) : '0);
    if (freed_sum > FREED_MAX) freed_sum = FREED_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      freed_q <= '0;
    end else begin
      out_q   <= out_d;
      freed_q <= freed_sum[FREED_W-1:0];
    end
  end

  assign freed_o = freed_q;

  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> freed_o <= FREED_W'((1 << CNT_W) - 1));

  p_freed_monotone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> freed_o >= $past(freed_o));

  p_overrun_no_change_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_bad_o && !ack_i) |=> $stable(freed_o));
endmodule

// File: rtl/tx_cmpl_tracker.sv
module tx_cmpl_tracker
  import tct_pkg::*;
#(
  parameter int TAG_W   = 16,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 5,
  parameter int FREED_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sub_valid_i,
  input  logic [TAG_W-1:0]   sub_tag_i,
  input  logic [CNT_W-1:0]   sub_ndesc_i,
  input  logic               cmp_valid_i,
  input  logic [1:0]         cmp_type_i,
  input  logic [TAG_W-1:0]   cmp_tag_i,
  input  logic [CNT_W-1:0]   cmp_ndesc_i,
  input  logic               freed_ack_i,
  output logic               done_o,
  output logic [TAG_W-1:0]   done_tag_o,
  output logic [FREED_W-1:0] freed_o,
  output logic               err_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HI_W  = TAG_W - IDX_W;
  localparam int OUT_W = CNT_W + IDX_W;

  slot_st_e        slot_st [DEPTH];
  logic [HI_W-1:0] slot_hi [DEPTH];

  logic [IDX_W-1:0] sub_idx, cmp_idx;
  slot_st_e         sub_st, cmp_st, adv_st;
  logic             sub_ok, sub_bad, tag_match;
  logic             adv, finish, cmp_bad, desc_req, desc_bad;
  cmpl_e            cmp_ty;

  assign sub_idx = sub_tag_i[IDX_W-1:0];
  assign cmp_idx = cmp_tag_i[IDX_W-1:0];
  assign sub_st  = slot_st[sub_idx];
  assign cmp_st  = slot_st[cmp_idx];
  assign sub_ok  = sub_valid_i && (sub_st == ST_FREE);
  assign sub_bad = sub_valid_i && !sub_ok;

  always_comb begin
    cmp_ty    = cmpl_e'(cmp_type_i);
    tag_match = slot_hi[cmp_idx] == cmp_tag_i[TAG_W-1:IDX_W];
    adv       = 1'b0;
    adv_st    = cmp_st;
    finish    = 1'b0;
    cmp_bad   = 1'b0;
    desc_req  = 1'b0;
    if (cmp_valid_i) begin
      unique case (cmp_ty)
        CT_DESC: desc_req = 1'b1;
        CT_PKT: begin
          if (tag_match && cmp_st == ST_PEND) begin
            adv = 1'b1; adv_st = ST_DONE; finish = 1'b1;
          end else cmp_bad = 1'b1;
        end
        CT_MISS: begin
          if (tag_match && cmp_st == ST_PEND) begin
            adv = 1'b1; adv_st = ST_MISS;
          end else cmp_bad = 1'b1;
        end
        CT_REINJ: begin
          if (tag_match && cmp_st == ST_MISS) begin
            adv = 1'b1; adv_st = ST_DONE; finish = 1'b1;
          end else cmp_bad = 1'b1;
        end
        default: cmp_bad = 1'b1;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    tct_slot #(.HI_W(HI_W)) i_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sub_go_i (sub_ok && (sub_idx == IDX_W'(i))),
      .sub_hi_i (sub_tag_i[TAG_W-1:IDX_W]),
      .adv_i    (adv && (cmp_idx == IDX_W'(i))),
      .adv_st_i (adv_st),
      .st_o     (slot_st[i]),
      .hi_o     (slot_hi[i])
    );
  end

  tct_desc_acct #(.CNT_W(CNT_W), .OUT_W(OUT_W), .FREED_W(FREED_W)) i_acct (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .add_i     (sub_ok),
    .add_n_i   (sub_ndesc_i),
    .rel_req_i (desc_req),
    .rel_n_i   (cmp_ndesc_i),
    .ack_i     (freed_ack_i),
    .freed_o   (freed_o),
    .rel_bad_o (desc_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      done_tag_o <= '0;
      err_o      <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) done_tag_o <= cmp_tag_i;
      err_o  <= sub_bad | cmp_bad | desc_bad;
    end
  end

  p_done_needs_cmpl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmp_valid_i));

  p_err_has_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(sub_valid_i || cmp_valid_i));

  p_desc_no_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && cmp_type_i == 2'd1) |=> !done_o);
endmodule

// File: tb/test_tx_cmpl_tracker.sv
module test_tx_cmpl_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_v = 1'b0;
  logic [15:0] sub_tag = '0;
  logic [4:0]  sub_n = '0;
  logic        cmp_v = 1'b0;
  logic [1:0]  cmp_ty = '0;
  logic [15:0] cmp_tag = '0;
  logic [4:0]  cmp_n = '0;
  logic        ack = 1'b0;
  logic        done;
  logic [15:0] done_tag;
  logic [11:0] freed;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tx_cmpl_tracker i_tx_cmpl_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .sub_valid_i(sub_v), .sub_tag_i(sub_tag), .sub_ndesc_i(sub_n),
    .cmp_valid_i(cmp_v), .cmp_type_i(cmp_ty), .cmp_tag_i(cmp_tag), .cmp_ndesc_i(cmp_n),
    .freed_ack_i(ack),
    .done_o(done), .done_tag_o(done_tag), .freed_o(freed), .err_o(err)
  );

  typedef struct packed {
    logic        sv;
    logic [15:0] st;
    logic [4:0]  sn;
    logic        cv;
    logic [1:0]  ct;
    logic [15:0] ctag;
    logic [4:0]  cn;
    logic        ack;
    logic        ed;
    logic [15:0] etag;
    logic        ee;
    logic [11:0] ef;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 18;
  // type: 0 pkt, 1 desc, 2 miss, 3 reinj
  localparam vec_t VECS [NV] = '{
    '{1, 16'h0011, 3, 0, 0, 16'h0000, 0, 0, 0, 16'h0000, 0, 0, 2},  // R2
    '{1, 16'h0022, 2, 0, 0, 16'h0000, 0, 0, 0, 16'h0000, 0, 0, 2},  // R2
    '{1, 16'h0011, 1, 0, 0, 16'h0000, 0, 0, 0, 16'h0000, 1, 0, 2},  // R2 in use
    '{0, 16'h0000, 0, 1, 0, 16'h0022, 0, 0, 1, 16'h0022, 0, 0, 11}, // R11 out of order
    '{1, 16'h0032, 1, 0, 0, 16'h0000, 0, 0, 0, 16'h0000, 1, 0, 3},  // R3 done cycle
    '{1, 16'h0032, 1, 0, 0, 16'h0000, 0, 0, 0, 16'h0000, 0, 0, 3},  // R3 freed
    '{0, 16'h0000, 0, 1, 2, 16'h0011, 0, 0, 0, 16'h0000, 0, 0, 4},  // R4 miss
    '{0, 16'h0000, 0, 1, 0, 16'h0011, 0, 0, 0, 16'h0000, 1, 0, 5},  // R5
    '{0, 16'h0000, 0, 1, 3, 16'h0032, 0, 0, 0, 16'h0000, 1, 0, 6},  // R6
    '{0, 16'h0000, 0, 1, 3, 16'h0011, 0, 0, 1, 16'h0011, 0, 0, 4},  // R4 reinj
    '{0, 16'h0000, 0, 1, 0, 16'h0045, 0, 0, 0, 16'h0000, 1, 0, 7},  // R7 free
    '{0, 16'h0000, 0, 1, 0, 16'h0132, 0, 0, 0, 16'h0000, 1, 0, 7},  // R7 alias
    '{0, 16'h0000, 0, 1, 1, 16'h0099, 4, 0, 0, 16'h0000, 0, 4, 8},  // R8
    '{0, 16'h0000, 0, 1, 1, 16'h0000, 3, 0, 0, 16'h0000, 1, 4, 10}, // R10
    '{0, 16'h0000, 0, 1, 1, 16'h0000, 2, 1, 0, 16'h0000, 0, 2, 9},  // R9 ack+desc
    '{0, 16'h0000, 0, 0, 0, 16'h0000, 0, 1, 0, 16'h0000, 0, 0, 9},  // R9 ack
    '{1, 16'h0043, 5, 1, 0, 16'h0032, 0, 0, 1, 16'h0032, 0, 0, 12}, // R12
    '{0, 16'h0000, 0, 1, 0, 16'h0043, 0, 0, 1, 16'h0043, 0, 0, 12}  // R12
  };

  task automatic check(string what, int rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    @(negedge clk);
    sub_v = v.sv; sub_tag = v.st; sub_n = v.sn;
    cmp_v = v.cv; cmp_ty = v.ct; cmp_tag = v.ctag; cmp_n = v.cn;
    ack = v.ack;
    @(posedge clk);
    #1;
    sub_v = 1'b0; cmp_v = 1'b0; ack = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    vec_t v;
    #1;
    check("reset done", 1, 32'(done), 0);   // R1
    check("reset err", 1, 32'(err), 0);
    check("reset freed", 1, 32'(freed), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      drive(v);
      check($sformatf("vec%0d err", i), int'(v.rq), 32'(err), 32'(v.ee));
      check($sformatf("vec%0d done", i), int'(v.rq), 32'(done), 32'(v.ed));
      check($sformatf("vec%0d freed", i), int'(v.rq), 32'(freed), 32'(v.ef));
      if (v.ed) check($sformatf("vec%0d tag", i), int'(v.rq), 32'(done_tag), 32'(v.etag));
    end

    // R1: reset frees a pending entry and zeroes freed counter
    drive('{1, 16'h0055, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1});
    drive('{0, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0, 1, 8});
    check("pre-reset freed", 8, 32'(freed), 1);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("reset freed", 1, 32'(freed), 0);
    @(negedge clk) rst_n = 1'b1;
    drive('{1, 16'h0055, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1});
    check("resubmit after reset err", 1, 32'(err), 0);
    // R1: outstanding total cleared; only the 2 just submitted may be freed
    drive('{0, 0, 0, 1, 1, 0, 3, 0, 0, 0, 0, 0, 10});
    check("outstanding after reset err", 1, 32'(err), 1);
    drive('{0, 0, 0, 1, 0, 16'h0055, 0, 0, 0, 0, 0, 0, 3});
    check("pkt after reset done", 3, 32'(done), 1);
    check("pkt after reset tag", 3, 32'(done_tag), 32'h0055);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule